// File: doc/BRIEF.md
# Copy-Back Sector Edit Guard

This block sits beside a flash controller and watches the column writes it issues into the page buffer between the copy-back read and the copy-back program. A page buffer of 2112 columns is split into four sectors. Each sector owns a 512-column main area in the low part of the column space and a 16-column spare area in the high part. The on-chip error detection can only stay valid if every sector that is edited gets all 528 of its columns rewritten, and if that happens in a single pass.

The guard keeps a coverage bitmap for each sector. A column write that lands on a column already written, or that returns to a sector after another sector has been edited, counts as a second edit and flags that sector at once. When the program strobe arrives, every sector that was edited but not fully covered is flagged, and a summary error is latched. A write to a column beyond the page raises a separate out-of-range flag. The copy-back-read start strobe clears all state for the next operation.

Top module: `cbk_edit_guard`

## Requirements
- R1: A column c below 2048 belongs to sector c/512 (integer division), and its offset in that sector is c mod 512.
- R2: A column c from 2048 to 2111 belongs to sector (c-2048)/16, and its offset in that sector is 512 + (c-2048) mod 16.
- R3: A sector with all 528 of its columns written, in any order and with each column written once, is not flagged when the program strobe arrives.
- R4: On the program strobe, every sector with at least one but not all of its columns written gets its bit in viol_o set from the next cycle on, and err_o reads 1 from that cycle on.
- R5: A sector with no column written is never flagged by the program strobe, and err_o reads 0 after a program strobe when no flag of any kind is set.
- R6: Writing a column of sector n that was already written since the last start strobe sets viol_o[n] from the next cycle on.
- R7: Writing sector n again after a write to a different sector that followed n's first write sets viol_o[n] from the next cycle on; the other sector is not flagged by this.
- R8: A write to column 2112 or above sets oor_o from the next cycle on, marks no sector, and makes err_o read 1 after the next program strobe.
- R9: The start strobe clears viol_o, oor_o, err_o and all coverage from the next cycle on; a write presented in the same cycle as the start strobe is ignored.
- R10: A write presented in the same cycle as the program strobe is ignored; viol_o and oor_o bits stay set until a start strobe, and err_o changes only on a program or start strobe.
- R11: After reset viol_o, oor_o and err_o are all 0 and no coverage is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Copy-back read start strobe, clears all state |
| wr_valid_i | input | 1 | A column write into the page buffer happens this cycle |
| wr_col_i | input | 12 | Column address of the write |
| prog_i | input | 1 | Copy-back program strobe, evaluates coverage |
| viol_o | output | 4 | Per-sector violation flags, bit n for sector n |
| oor_o | output | 1 | A write outside the page was seen |
| err_o | output | 1 | Summary error latched at the program strobe |

## Verification
The assertions watch, on every cycle, that flags never drop without a start strobe, that the summary error moves only on a strobe, that the start strobe empties everything, that a repeated column or an out-of-range column raises its flag one cycle later, and that a full bitmap stays full. Whether the column-to-sector mapping is right across both areas, whether full coverage in scrambled order passes cleanly, and whether re-entering a sector is told apart from writing a fresh one can only be shown by the bench's scenarios against its reference model.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
  localparam int MAIN_BYTES  = 512;
  localparam int SPARE_BYTES = 16;
  localparam int SECTORS     = 4;
  localparam int COL_W       = 12;
endpackage

// File: rtl/cbk_col_decode.sv
module cbk_col_decode #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int SECTORS     = 4,
  parameter int COL_W       = 12,
  localparam int SEC_W      = $clog2(SECTORS),
  localparam int OFF_W      = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic [COL_W-1:0] col_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [OFF_W-1:0] off_o,
  output logic             oor_o
);
  localparam logic [COL_W-1:0] MAIN_C  = COL_W'(MAIN_BYTES);
  localparam logic [COL_W-1:0] SPARE_C = COL_W'(SPARE_BYTES);
  localparam logic [COL_W-1:0] SBASE_C = COL_W'(MAIN_BYTES * SECTORS);
  localparam logic [COL_W-1:0] PAGE_C  = COL_W'(MAIN_BYTES * SECTORS + SPARE_BYTES * SECTORS);

  logic [COL_W-1:0] rel;

  always_comb begin
    rel   = col_i - SBASE_C;
    sec_o = '0;
    off_o = '0;
    oor_o = 1'b0;
    if (col_i < SBASE_C) begin
      sec_o = SEC_W'(col_i / MAIN_C);
      off_o = OFF_W'(col_i % MAIN_C);
    end else if (col_i < PAGE_C) begin
      sec_o = SEC_W'(rel / SPARE_C);
      off_o = OFF_W'(MAIN_C + (rel % SPARE_C));
    end else begin
      oor_o = 1'b1;
    end
  end
endmodule

// File: rtl/cbk_sector_track.sv
module cbk_sector_track #(
  parameter int SEC_BYTES = 528,
  localparam int OFF_W    = $clog2(SEC_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             dup_o,
  output logic             touched_o,
  output logic             full_o
);
  logic [SEC_BYTES-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (clr_i)      map_d = '0;
    else if (hit_i) map_d[off_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  assign dup_o     = map_q[off_i];
  assign touched_o = |map_q;
  assign full_o    = &map_q;

  // R3: full coverage is kept until cleared
  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clr_i) |=> full_o);
  // R9: a clear leaves no coverage behind
  p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !touched_o);
  // R6: a fresh hit is recorded on the next cycle
  p_hit_recorded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !clr_i) |=> touched_o);
endmodule

// File: rtl/cbk_edit_guard.sv
module cbk_edit_guard #(
  parameter int MAIN_BYTES  = cbk_pkg::MAIN_BYTES,
  parameter int SPARE_BYTES = cbk_pkg::SPARE_BYTES,
  parameter int SECTORS     = cbk_pkg::SECTORS,
  parameter int COL_W       = cbk_pkg::COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               wr_valid_i,
  input  logic [COL_W-1:0]   wr_col_i,
  input  logic               prog_i,
  output logic [SECTORS-1:0] viol_o,
  output logic               oor_o,
  output logic               err_o
);
  localparam int SEC_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int SEC_W     = $clog2(SECTORS);
  localparam int OFF_W     = $clog2(SEC_BYTES);

  logic [SEC_W-1:0]   dec_sec;
  logic [OFF_W-1:0]   dec_off;
  logic               dec_oor;
  logic               wr_acc;
  logic [SECTORS-1:0] hit, dup, touched, full, second_mod, other_wr;
  logic [SECTORS-1:0] closed_q, closed_d, viol_q, viol_d;
  logic               oor_q, oor_d, err_q, err_d;

  cbk_col_decode #(
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .SECTORS(SECTORS), .COL_W(COL_W)
  ) u_dec (
    .col_i(wr_col_i), .sec_o(dec_sec), .off_o(dec_off), .oor_o(dec_oor)
  );

  assign wr_acc = wr_valid_i && !start_i && !prog_i;

  for (genvar n = 0; n < SECTORS; n++) begin : g_sec
    assign hit[n]      = wr_acc && !dec_oor && (dec_sec == SEC_W'(n));
    assign other_wr[n] = wr_acc && !dec_oor && (dec_sec != SEC_W'(n));
    cbk_sector_track #(.SEC_BYTES(SEC_BYTES)) u_trk (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .hit_i(hit[n]),
      .off_i(dec_off), .dup_o(dup[n]), .touched_o(touched[n]), .full_o(full[n])
    );
    assign second_mod[n] = hit[n] && (dup[n] || closed_q[n]);
  end

  always_comb begin
    closed_d = closed_q;
    viol_d   = viol_q;
    oor_d    = oor_q;
    err_d    = err_q;
    if (start_i) begin
      closed_d = '0;
      viol_d   = '0;
      oor_d    = 1'b0;
      err_d    = 1'b0;
    end else if (prog_i) begin
      viol_d = viol_q | (touched & ~full);
      err_d  = (|viol_d) || oor_q;
    end else begin
      closed_d = closed_q | (touched & other_wr);
      viol_d   = viol_q | second_mod;
      oor_d    = oor_q | (wr_acc && dec_oor);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      closed_q <= '0;
      viol_q   <= '0;
      oor_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      closed_q <= closed_d;
      viol_q   <= viol_d;
      oor_q    <= oor_d;
      err_q    <= err_d;
    end
  end

  assign viol_o = viol_q;
  assign oor_o  = oor_q;
  assign err_o  = err_q;

  // R9: start strobe empties all flags
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (viol_o == '0 && !oor_o && !err_o));
  // R8: out-of-range write raises its flag
  p_oor_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !start_i && !prog_i &&
     wr_col_i >= COL_W'(MAIN_BYTES * SECTORS + SPARE_BYTES * SECTORS)) |=> oor_o);
  // R10: flags never drop without a start strobe
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((($past(viol_o) & ~viol_o) == '0) && !($past(oor_o) && !oor_o)));
  // R10: summary error moves only on a strobe
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !prog_i) |=> $stable(err_o));
  // R4: partial sectors are flagged at program time
  p_partial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_i && !start_i) |=>
      ((viol_o & $past(touched & ~full)) == $past(touched & ~full)));
  // R6: a repeated column flags its sector
  p_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & dup)) |=> ((viol_o & $past(hit & dup)) == $past(hit & dup)));
  // R7: at most one sector is open at a time
  p_single_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(touched & ~closed_q) <= 1);
endmodule

// File: tb/test_cbk_edit_guard.sv
module test_cbk_edit_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, wr_valid_i = 1'b0, prog_i = 1'b0;
  logic [11:0] wr_col_i = '0;
  logic [3:0]  viol_o;
  logic        oor_o, err_o;

  int checks = 0, failures = 0, cycles = 0;
  bit model_on = 1'b0;

  // reference model state
  bit [527:0] m_map [4];
  bit [3:0]   m_closed, m_viol;
  bit         m_oor, m_err;

  always #5 clk = ~clk;

  cbk_edit_guard i_cbk_edit_guard (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_valid_i(wr_valid_i),
    .wr_col_i(wr_col_i), .prog_i(prog_i), .viol_o(viol_o), .oor_o(oor_o), .err_o(err_o)
  );

  function automatic bit m_touched(int s);
    return |m_map[s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) m_map[s] = '0;
      m_closed = '0; m_viol = '0; m_oor = 0; m_err = 0;
    end else if (start_i) begin
      for (int s = 0; s < 4; s++) m_map[s] = '0;
      m_closed = '0; m_viol = '0; m_oor = 0; m_err = 0;
    end else if (prog_i) begin
      for (int s = 0; s < 4; s++)
        if (m_touched(s) && !(&m_map[s])) m_viol[s] = 1;
      m_err = (m_viol != 0) || m_oor;
    end else if (wr_valid_i) begin
      int c, sec, off;
      c = wr_col_i;
      if (c >= 2112) m_oor = 1;
      else begin
        if (c < 2048) begin sec = c / 512; off = c % 512; end
        else begin sec = (c - 2048) / 16; off = 512 + (c - 2048) % 16; end
        if (m_map[sec][off] || m_closed[sec]) m_viol[sec] = 1;
        for (int s = 0; s < 4; s++)
          if (s != sec && m_touched(s)) m_closed[s] = 1;
        m_map[sec][off] = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      checks++;
      if (viol_o !== m_viol || oor_o !== m_oor || err_o !== m_err) begin
        failures++;
        $display("FAIL model R4 R6 R7 R8 R10: actual viol=%b oor=%b err=%b expected viol=%b oor=%b err=%b",
                 viol_o, oor_o, err_o, m_viol, m_oor, m_err);
      end
    end
  end

  task automatic step(bit st, bit pg, bit wv, int col);
    start_i = st; prog_i = pg; wr_valid_i = wv; wr_col_i = 12'(col);
    @(negedge clk);
    start_i = 0; prog_i = 0; wr_valid_i = 0;
  endtask

  task automatic wr(int col);
    step(0, 0, 1, col);
  endtask

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic whole_sector(int s, bit rev);
    for (int i = 0; i < 528; i++) begin
      int k, col;
      k = rev ? 527 - i : i;
      col = (k < 512) ? s * 512 + k : 2048 + s * 16 + (k - 512);
      wr(col);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset", {viol_o, oor_o, err_o}, 6'b0);
    model_on = 1'b1;

    // R1 R2 R3 R5: sector 0 in ascending order, clean program
    whole_sector(0, 0);
    step(0, 1, 0, 0);
    chk("R3 full sector0 clean", {viol_o, oor_o, err_o}, 6'b0);
    chk("R5 untouched not flagged", {2'b0, viol_o[3:1]}, 6'b0);

    // R4: sector 2 reversed (spare first), sector 3 main only
    step(1, 0, 0, 0);
    whole_sector(2, 1);
    for (int i = 1536; i < 2048; i++) wr(i);
    step(0, 1, 0, 0);
    chk("R4 partial sector3", {viol_o, oor_o, err_o}, 6'b1000_0_1);

    // R9: start clears
    step(1, 0, 0, 0);
    chk("R9 start clears", {viol_o, oor_o, err_o}, 6'b0);

    // R6: same column twice
    wr(5);
    chk("R6 first write clean", {2'b0, viol_o}, 6'b0);
    wr(5);
    chk("R6 duplicate column", {2'b0, viol_o}, 6'b0001);

    // R7: re-entering sector 1 after sector 0
    step(1, 0, 0, 0);
    wr(600); wr(10);
    chk("R7 before reentry", {2'b0, viol_o}, 6'b0);
    wr(601);
    chk("R7 reentry sector1", {2'b0, viol_o}, 6'b0010);
    // R2: spare column of sector 1 (2064) is also a reentry
    step(1, 0, 0, 0);
    wr(2064); wr(2048); wr(2065);
    chk("R2 spare map sector1", {2'b0, viol_o}, 6'b0010);

    // R8: out-of-range
    step(1, 0, 0, 0);
    wr(2112);
    chk("R8 oor 2112", {viol_o, oor_o, err_o}, 6'b0000_1_0);
    wr(4095);
    step(0, 1, 0, 0);
    chk("R8 oor err at prog", {viol_o, oor_o, err_o}, 6'b0000_1_1);

    // R9: write with start ignored
    step(1, 0, 1, 7);
    step(0, 1, 0, 0);
    chk("R9 write with start ignored", {viol_o, oor_o, err_o}, 6'b0);

    // R10: write with prog ignored, flags sticky, err only on strobes
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    chk("R10 write with prog ignored", {viol_o, oor_o, err_o}, 6'b0);
    wr(3); wr(3);
    chk("R10 err waits for prog", {viol_o, oor_o, err_o}, 6'b0001_0_0);
    repeat (3) step(0, 0, 0, 0);
    chk("R10 viol sticky", {2'b0, viol_o}, 6'b0001);
    step(0, 1, 0, 0);
    chk("R10 err after prog", {viol_o, oor_o, err_o}, 6'b0001_0_1);

    // R1: main column of sector 3 boundary
    step(1, 0, 0, 0);
    wr(1535); wr(1536); wr(1535);
    chk("R1 main boundary", {2'b0, viol_o}, 6'b0100);

    model_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog R11: actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule